// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Arithmetic Slice

This block is a wide arithmetic slice with one register stage on its result. A signed 25-bit by 18-bit multiplier, a 48-bit three-input adder/subtracter and a 48-bit bitwise logic unit share one registered output. Three separately controlled operand multiplexers pick the terms from a fixed set: the product, the two narrow operands joined into one wide word, a wide side operand, a cascade input, the fed-back result (plain or shifted), and the constants zero and all ones. The same hardware can therefore do a multiply, a multiply-accumulate, a wide add or subtract, a shifted accumulate for multi-word arithmetic, or a bitwise operation.

A masked equality detector runs on each new result and registers together with it. It reports a match against a pattern and a match against the inverse of that pattern. Combined with the logic unit, it can test a bitwise combination of two wide fields against a constant in one cycle. Operand and function combinations that make no sense are flagged, and the stored result is then left untouched.

Top module: `mac_slice`

## Requirements
- R1: When `rst` is high at a rising edge, `pOut`, `carryOut`, `patDet`, `patDetInv` and `opErr` all become 0 on that edge, whatever `ce` is.
- R2: When `rst` is low and `ce` is low at a rising edge, every registered output keeps its value.
- R3: With `opSel[1:0]`=01, `opSel[3:2]`=01 and `opSel[6:4]`=000, and with add mode selected, `pOut` becomes the signed product of `aIn` and `bIn`, sign-extended to 48 bits, plus the carry-in. With `opSel[6:4]`=010, the product is added to the previous `pOut` (accumulate).
- R4: X operand (`opSel[1:0]`): 00 is zero, 01 is the product, 10 is `pOut`, and 11 is the zero-extended joined word with `aIn` in bits 42:18 and `bIn` in bits 17:0. Y operand (`opSel[3:2]`): 00 is zero, 01 is the product companion (zero), 10 is all ones, and 11 is `cIn`. Z operand (`opSel[6:4]`): 000 is zero, 001 is `casIn`, 010 is `pOut`, and 011 is `cIn`.
- R5: `fnSel`=0000 gives Z+X+Y+cin and `fnSel`=0011 gives Z−(X+Y+cin), both modulo 2^48.
- R6: `fnSel` codes 0100, 1100, 1110 and 1111 give X XOR Z, X AND Z, X OR Z and NOT(X AND Z).
- R7: In add mode, `carryOut` is 1 when the unsigned sum exceeds 2^48−1. In subtract mode, it is 1 when X+Y+cin is larger than Z (borrow). In logic modes and whenever the product is selected, it is 0.
- R8: An illegal setting sets `opErr` to 1 and leaves `pOut`, `carryOut`, `patDet` and `patDetInv` unchanged. Illegal settings are: the product on only one of X and Y; Z code 100 or 111; an unlisted `fnSel`; or a logic mode with Y set to 01 or 11. A legal cycle with `ce` high clears `opErr`.
- R9: `patDet` registers 1 when the new result equals `patIn` on every bit where `maskIn` is 0. `patDetInv` registers 1 when the new result equals the inverse of `patIn` on those same bits. Bits where `maskIn` is 1 are ignored.
- R10: Z code 101 selects `casIn` and Z code 110 selects `pOut`, each arithmetically shifted right by 17.
- R11: `carrySel` chooses the carry-in: 00 is the `carryIn` pin, 01 is `casIn[47]`, 10 is `pOut[47]`, and 11 is constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of all registered outputs |
| ce | input | 1 | Clock enable for the result stage |
| aIn | input | 25 | Signed multiplier operand, high part of joined word |
| bIn | input | 18 | Signed multiplier operand, low part of joined word |
| cIn | input | 48 | Wide side operand |
| casIn | input | 48 | Cascade input from a neighbouring slice |
| opSel | input | 7 | Operand-select word for X, Y and Z |
| fnSel | input | 4 | Function-select word |
| carrySel | input | 2 | Carry-in source select |
| carryIn | input | 1 | External carry-in bit |
| patIn | input | 48 | Pattern for the detector |
| maskIn | input | 48 | Detector mask, 1 = ignore bit |
| pOut | output | 48 | Registered result |
| carryOut | output | 1 | Registered carry or borrow |
| patDet | output | 1 | Registered masked match against pattern |
| patDetInv | output | 1 | Registered masked match against inverted pattern |
| opErr | output | 1 | Registered illegal-setting flag |

## Verification
The multiplier is driven with a negative-by-positive product and then accumulated with a second product. This separates correct sign extension and feedback from a plain zero-extended or non-accumulating path. Wide adds run with and without wrap-around, and subtracts run with and without borrow, so the carry convention of each mode is pinned down. Each logic code is applied to the same pair of alternating-bit words, so any swap of two codes shows up. Pattern tests vary only the mask and the pattern polarity on a fixed result, which tells masking apart from inversion.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

  typedef enum logic [1:0] {
    X_ZERO = 2'b00,
    X_PROD = 2'b01,
    X_PREG = 2'b10,
    X_AB   = 2'b11
  } xSel_e;

  typedef enum logic [1:0] {
    Y_ZERO  = 2'b00,
    Y_PCOMP = 2'b01,
    Y_ONES  = 2'b10,
    Y_C     = 2'b11
  } ySel_e;

  typedef enum logic [2:0] {
    Z_ZERO  = 3'b000,
    Z_CAS   = 3'b001,
    Z_PREG  = 3'b010,
    Z_C     = 3'b011,
    Z_RSV4  = 3'b100,
    Z_CASSH = 3'b101,
    Z_PSH   = 3'b110,
    Z_RSV7  = 3'b111
  } zSel_e;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_SUB,
    OP_XOR,
    OP_AND,
    OP_OR,
    OP_NAND
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_PIN   = 2'b00,
    CIN_CASMS = 2'b01,
    CIN_PMS   = 2'b10,
    CIN_ZERO  = 2'b11
  } cinSel_e;

  typedef struct packed {
    xSel_e   xSel;
    ySel_e   ySel;
    zSel_e   zSel;
    aluOp_e  aluOp;
    cinSel_e cinSel;
    logic    multMode;
    logic    illegal;
  } strobes_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_slice_pkg::*;
(
  input  logic [6:0] opSel,
  input  logic [3:0] fnSel,
  input  logic [1:0] carrySel,
  output strobes_t   strb
);

  logic fnBad;
  logic zBad;
  logic logicMode;
  logic yLogicBad;
  logic prodMismatch;
  aluOp_e opDec;

  always_comb begin
    fnBad     = 1'b0;
    logicMode = 1'b0;
    opDec     = OP_ADD;
    unique case (fnSel)
      4'b0000: opDec = OP_ADD;
      4'b0011: opDec = OP_SUB;
      4'b0100: begin opDec = OP_XOR;  logicMode = 1'b1; end
      4'b1100: begin opDec = OP_AND;  logicMode = 1'b1; end
      4'b1110: begin opDec = OP_OR;   logicMode = 1'b1; end
      4'b1111: begin opDec = OP_NAND; logicMode = 1'b1; end
      default: fnBad = 1'b1;
    endcase
  end

  always_comb begin
    zBad = (opSel[6:4] == 3'b100) || (opSel[6:4] == 3'b111);
  end

  assign prodMismatch = (opSel[1:0] == 2'b01) != (opSel[3:2] == 2'b01);
  assign yLogicBad    = logicMode && opSel[2];

  always_comb begin
    strb.xSel     = xSel_e'(opSel[1:0]);
    strb.ySel     = ySel_e'(opSel[3:2]);
    strb.zSel     = zSel_e'(opSel[6:4]);
    strb.aluOp    = opDec;
    strb.cinSel   = cinSel_e'(carrySel);
    strb.multMode = (opSel[1:0] == 2'b01);
    strb.illegal  = fnBad || zBad || prodMismatch || yLogicBad;
  end

endmodule

// File: rtl/mac_alu.sv
module mac_alu
  import mac_slice_pkg::*;
#(
  parameter int PW = 48
) (
  input  logic [PW-1:0] xOp,
  input  logic [PW-1:0] yOp,
  input  logic [PW-1:0] zOp,
  input  logic          cin,
  input  aluOp_e        aluOp,
  output logic [PW-1:0] res,
  output logic          cout
);

  localparam int EW = PW + 2;

  logic [EW-1:0] addSum;
  logic [EW-1:0] subTerm;
  logic [EW-1:0] subDiff;

  assign addSum  = EW'(zOp) + EW'(xOp) + EW'(yOp) + EW'(cin);
  assign subTerm = EW'(xOp) + EW'(yOp) + EW'(cin);
  assign subDiff = EW'(zOp) - subTerm;

  always_comb begin
    res  = '0;
    cout = 1'b0;
    unique case (aluOp)
      OP_ADD: begin
        res  = addSum[PW-1:0];
        cout = |addSum[EW-1:PW];
      end
      OP_SUB: begin
        res  = subDiff[PW-1:0];
        cout = subTerm > EW'(zOp);
      end
      OP_XOR:  res = xOp ^ zOp;
      OP_AND:  res = xOp & zOp;
      OP_OR:   res = xOp | zOp;
      OP_NAND: res = ~(xOp & zOp);
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/mac_patdet.sv
module mac_patdet #(
  parameter int PW = 48
) (
  input  logic [PW-1:0] value,
  input  logic [PW-1:0] pattern,
  input  logic [PW-1:0] mask,
  output logic          hit,
  output logic          hitInv
);

  assign hit    = ~|((value ^  pattern) & ~mask);
  assign hitInv = ~|((value ^ ~pattern) & ~mask);

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_slice_pkg::*;
#(
  parameter int AW    = 25,
  parameter int BW    = 18,
  parameter int PW    = 48,
  parameter int SHIFT = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  strobes_t      strb,
  input  logic [AW-1:0] aIn,
  input  logic [BW-1:0] bIn,
  input  logic [PW-1:0] cIn,
  input  logic [PW-1:0] casIn,
  input  logic          carryIn,
  input  logic [PW-1:0] patIn,
  input  logic [PW-1:0] maskIn,
  output logic [PW-1:0] pOut,
  output logic          carryOut,
  output logic          patDet,
  output logic          patDetInv,
  output logic          opErr
);

  localparam int PRODW = AW + BW;
  localparam int ABW   = AW + BW;

  logic signed [AW-1:0]    aS;
  logic signed [BW-1:0]    bS;
  logic signed [PRODW-1:0] prod;
  logic [PW-1:0]           prodExt;
  logic [PW-1:0]           abWord;
  logic signed [PW-1:0]    casS;
  logic signed [PW-1:0]    pS;
  logic [PW-1:0]           casSh;
  logic [PW-1:0]           pSh;
  logic [PW-1:0]           xOp, yOp, zOp;
  logic                    cin;
  logic [PW-1:0]           aluRes;
  logic                    aluCout;
  logic                    hit, hitInv;

  logic [PW-1:0] pReg;
  logic          coReg, pdReg, pdiReg, errReg;

  assign aS      = aIn;
  assign bS      = bIn;
  assign prod    = aS * bS;
  assign prodExt = {{(PW-PRODW){prod[PRODW-1]}}, prod};
  assign abWord  = {{(PW-ABW){1'b0}}, aIn, bIn};
  assign casS    = casIn;
  assign pS      = pReg;
  assign casSh   = casS >>> SHIFT;
  assign pSh     = pS >>> SHIFT;

  always_comb begin
    unique case (strb.xSel)
      X_ZERO:  xOp = '0;
      X_PROD:  xOp = prodExt;
      X_PREG:  xOp = pReg;
      X_AB:    xOp = abWord;
      default: xOp = '0;
    endcase
  end

  always_comb begin
    unique case (strb.ySel)
      Y_ZERO:  yOp = '0;
      Y_PCOMP: yOp = '0;
      Y_ONES:  yOp = '1;
      Y_C:     yOp = cIn;
      default: yOp = '0;
    endcase
  end

  always_comb begin
    unique case (strb.zSel)
      Z_CAS:   zOp = casIn;
      Z_PREG:  zOp = pReg;
      Z_C:     zOp = cIn;
      Z_CASSH: zOp = casSh;
      Z_PSH:   zOp = pSh;
      default: zOp = '0;
    endcase
  end

  always_comb begin
    unique case (strb.cinSel)
      CIN_PIN:   cin = carryIn;
      CIN_CASMS: cin = casIn[PW-1];
      CIN_PMS:   cin = pReg[PW-1];
      default:   cin = 1'b0;
    endcase
  end

  mac_alu #(.PW(PW)) uAlu (
    .xOp   (xOp),
    .yOp   (yOp),
    .zOp   (zOp),
    .cin   (cin),
    .aluOp (strb.aluOp),
    .res   (aluRes),
    .cout  (aluCout)
  );

  mac_patdet #(.PW(PW)) uPat (
    .value   (aluRes),
    .pattern (patIn),
    .mask    (maskIn),
    .hit     (hit),
    .hitInv  (hitInv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pReg   <= '0;
      coReg  <= 1'b0;
      pdReg  <= 1'b0;
      pdiReg <= 1'b0;
      errReg <= 1'b0;
    end else if (ce) begin
      if (strb.illegal) begin
        errReg <= 1'b1;
      end else begin
        pReg   <= aluRes;
        coReg  <= strb.multMode ? 1'b0 : aluCout;
        pdReg  <= hit;
        pdiReg <= hitInv;
        errReg <= 1'b0;
      end
    end
  end

  assign pOut      = pReg;
  assign carryOut  = coReg;
  assign patDet    = pdReg;
  assign patDetInv = pdiReg;
  assign opErr     = errReg;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pOut == '0) && !opErr && !carryOut && !patDet && !patDetInv);

  // R2
  a_r2_ce_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(pOut) && $stable(opErr) && $stable(carryOut));

  // R7
  a_r7_mult_no_carry: assert property (@(posedge clk) disable iff (rst)
    (ce && !strb.illegal && strb.multMode) |=> !carryOut);

  // R8
  a_r8_illegal_holds: assert property (@(posedge clk) disable iff (rst)
    (ce && strb.illegal) |=> opErr && $stable(pOut) && $stable(patDet));

  // R8
  a_r8_legal_clears: assert property (@(posedge clk) disable iff (rst)
    (ce && !strb.illegal) |=> !opErr);

endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int AW    = 25,
  parameter int BW    = 18,
  parameter int PW    = 48,
  parameter int SHIFT = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [AW-1:0] aIn,
  input  logic [BW-1:0] bIn,
  input  logic [PW-1:0] cIn,
  input  logic [PW-1:0] casIn,
  input  logic [6:0]    opSel,
  input  logic [3:0]    fnSel,
  input  logic [1:0]    carrySel,
  input  logic          carryIn,
  input  logic [PW-1:0] patIn,
  input  logic [PW-1:0] maskIn,
  output logic [PW-1:0] pOut,
  output logic          carryOut,
  output logic          patDet,
  output logic          patDetInv,
  output logic          opErr
);

  strobes_t strb;

  mac_ctrl uCtrl (
    .opSel    (opSel),
    .fnSel    (fnSel),
    .carrySel (carrySel),
    .strb     (strb)
  );

  mac_datapath #(
    .AW(AW), .BW(BW), .PW(PW), .SHIFT(SHIFT)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .strb      (strb),
    .aIn       (aIn),
    .bIn       (bIn),
    .cIn       (cIn),
    .casIn     (casIn),
    .carryIn   (carryIn),
    .patIn     (patIn),
    .maskIn    (maskIn),
    .pOut      (pOut),
    .carryOut  (carryOut),
    .patDet    (patDet),
    .patDetInv (patDetInv),
    .opErr     (opErr)
  );

endmodule

// File: tb/tb_mac_slice.sv
module tb_mac_slice;

  logic        clk = 1'b0;
  logic        rst, ce, carryIn;
  logic [24:0] aIn;
  logic [17:0] bIn;
  logic [47:0] cIn, casIn, patIn, maskIn;
  logic [6:0]  opSel;
  logic [3:0]  fnSel;
  logic [1:0]  carrySel;
  logic [47:0] pOut;
  logic        carryOut, patDet, patDetInv, opErr;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  mac_slice dut (
    .clk(clk), .rst(rst), .ce(ce), .aIn(aIn), .bIn(bIn), .cIn(cIn),
    .casIn(casIn), .opSel(opSel), .fnSel(fnSel), .carrySel(carrySel),
    .carryIn(carryIn), .patIn(patIn), .maskIn(maskIn), .pOut(pOut),
    .carryOut(carryOut), .patDet(patDet), .patDetInv(patDetInv), .opErr(opErr)
  );

  localparam logic [6:0] MUL  = 7'b000_01_01;
  localparam logic [6:0] MACC = 7'b010_01_01;
  localparam logic [6:0] ABC  = 7'b011_00_11;
  localparam logic [6:0] ABOC = 7'b011_10_11;
  localparam logic [6:0] CONLY= 7'b011_00_00;

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] os, input logic [3:0] fs,
                      input logic [1:0] cs, input logic ci,
                      input logic [24:0] a, input logic [17:0] b,
                      input logic [47:0] c, input logic [47:0] cas);
    @(negedge clk);
    opSel = os; fnSel = fs; carrySel = cs; carryIn = ci;
    aIn = a; bIn = b; cIn = c; casIn = cas;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; ce = 1'b1;
    @(posedge clk); #1;
    chk("R1 pOut", pOut, 48'd0);
    chk("R1 flags", {44'd0, carryOut, patDet, patDetInv, opErr}, 48'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_mult();
    step(MUL, 4'b0000, 2'b11, 1'b0, -25'sd3, 18'd1000, 48'd0, 48'd0);
    chk("R3 signed product", pOut, 48'(-3000));
    chk("R7 carry zero in multiply", {47'd0, carryOut}, 48'd0);
    step(MACC, 4'b0000, 2'b00, 1'b1, 25'd2, 18'd5, 48'd0, 48'd0);
    chk("R3 accumulate", pOut, 48'(-2989));
  endtask

  task automatic t_addsub();
    step(ABC, 4'b0000, 2'b00, 1'b1, 25'd1, 18'd0, 48'd100, 48'd0);
    chk("R4 R5 joined word plus C plus cin", pOut, 48'd262245);
    chk("R7 no carry", {47'd0, carryOut}, 48'd0);
    step(ABOC, 4'b0000, 2'b00, 1'b0, 25'd0, 18'd0, 48'd5, 48'd0);
    chk("R5 wrap with all ones", pOut, 48'd4);
    chk("R7 add carry", {47'd0, carryOut}, 48'd1);
    step(ABC, 4'b0011, 2'b11, 1'b0, 25'd0, 18'd3, 48'd10, 48'd0);
    chk("R5 subtract", pOut, 48'd7);
    chk("R7 no borrow", {47'd0, carryOut}, 48'd0);
    step(ABC, 4'b0011, 2'b11, 1'b0, 25'd0, 18'd20, 48'd10, 48'd0);
    chk("R5 subtract negative", pOut, 48'(-10));
    chk("R7 borrow", {47'd0, carryOut}, 48'd1);
  endtask

  task automatic t_logic();
    logic [47:0] cv  = 48'hF0F0_F0F0_F0F0;
    logic [47:0] abv = 48'h0000_0000_3FFF_F;
    abv = {5'd0, 25'h0AAAAAA, 18'h15555};
    step(ABC, 4'b0100, 2'b00, 1'b1, abv[42:18], abv[17:0], cv, 48'd0);
    chk("R6 xor", pOut, abv ^ cv);
    chk("R7 carry zero in logic", {47'd0, carryOut}, 48'd0);
    step(ABC, 4'b1100, 2'b00, 1'b1, abv[42:18], abv[17:0], cv, 48'd0);
    chk("R6 and", pOut, abv & cv);
    step(ABC, 4'b1110, 2'b00, 1'b1, abv[42:18], abv[17:0], cv, 48'd0);
    chk("R6 or", pOut, abv | cv);
    step(ABC, 4'b1111, 2'b00, 1'b1, abv[42:18], abv[17:0], cv, 48'd0);
    chk("R6 nand", pOut, ~(abv & cv));
  endtask

  task automatic t_illegal();
    logic [47:0] held;
    step(CONLY, 4'b0000, 2'b11, 1'b0, 25'd0, 18'd0, 48'd77, 48'd0);
    held = pOut;
    chk("R4 Z selects C", held, 48'd77);
    step(7'b011_00_01, 4'b0000, 2'b11, 1'b0, 25'd9, 18'd9, 48'd1, 48'd0);
    chk("R8 lone product flag", {47'd0, opErr}, 48'd1);
    chk("R8 lone product holds P", pOut, held);
    step(7'b011_11_11, 4'b0100, 2'b11, 1'b0, 25'd1, 18'd1, 48'd2, 48'd0);
    chk("R8 logic with Y=C flag", {47'd0, opErr}, 48'd1);
    chk("R8 logic with Y=C holds P", pOut, held);
    step(7'b100_00_00, 4'b0000, 2'b11, 1'b0, 25'd0, 18'd0, 48'd3, 48'd0);
    chk("R8 reserved Z flag", {47'd0, opErr}, 48'd1);
    step(CONLY, 4'b0001, 2'b11, 1'b0, 25'd0, 18'd0, 48'd3, 48'd0);
    chk("R8 bad function holds P", pOut, held);
    step(CONLY, 4'b0000, 2'b11, 1'b0, 25'd0, 18'd0, 48'd3, 48'd0);
    chk("R8 legal clears flag", {47'd0, opErr}, 48'd0);
  endtask

  task automatic t_shift_cin();
    step(7'b101_00_00, 4'b0000, 2'b11, 1'b1, 25'd0, 18'd0, 48'd0, 48'(-(1 << 20)));
    chk("R10 cascade shifted", pOut, 48'(-8));
    step(CONLY, 4'b0000, 2'b10, 1'b0, 25'd0, 18'd0, 48'd7, 48'd0);
    chk("R11 carry from P sign", pOut, 48'd8);
    step(CONLY, 4'b0000, 2'b01, 1'b0, 25'd0, 18'd0, 48'd7, 48'(-1));
    chk("R11 carry from cascade sign", pOut, 48'd8);
    step(CONLY, 4'b0000, 2'b11, 1'b1, 25'd0, 18'd0, 48'd7, 48'd0);
    chk("R11 forced zero carry", pOut, 48'd7);
    step(CONLY, 4'b0000, 2'b00, 1'b1, 25'd0, 18'd0, 48'(5 * 131072 + 3), 48'd0);
    step(7'b110_00_00, 4'b0000, 2'b11, 1'b0, 25'd0, 18'd0, 48'd0, 48'd0);
    chk("R10 P shifted", pOut, 48'd5);
    step(7'b001_00_10, 4'b0000, 2'b11, 1'b0, 25'd0, 18'd0, 48'd0, 48'd100);
    chk("R4 cascade plus P", pOut, 48'd105);
  endtask

  task automatic t_pattern();
    logic [47:0] v = 48'h1234_5678_9ABC;
    patIn = v; maskIn = 48'd0;
    step(CONLY, 4'b0000, 2'b11, 1'b0, 25'd0, 18'd0, v, 48'd0);
    chk("R9 exact match", {46'd0, patDet, patDetInv}, 48'd2);
    patIn = v ^ 48'd1; maskIn = 48'd1;
    step(CONLY, 4'b0000, 2'b11, 1'b0, 25'd0, 18'd0, v, 48'd0);
    chk("R9 masked bit ignored", {46'd0, patDet, patDetInv}, 48'd2);
    maskIn = 48'd0;
    step(CONLY, 4'b0000, 2'b11, 1'b0, 25'd0, 18'd0, v, 48'd0);
    chk("R9 unmasked mismatch", {46'd0, patDet, patDetInv}, 48'd0);
    patIn = ~v;
    step(CONLY, 4'b0000, 2'b11, 1'b0, 25'd0, 18'd0, v, 48'd0);
    chk("R9 inverse match", {46'd0, patDet, patDetInv}, 48'd1);
  endtask

  task automatic t_ce_reset();
    @(negedge clk); ce = 1'b0;
    step(CONLY, 4'b0000, 2'b11, 1'b0, 25'd0, 18'd0, 48'd999, 48'd0);
    chk("R2 hold with ce low", pOut, 48'h1234_5678_9ABC);
    chk("R2 flags held", {46'd0, patDet, patDetInv}, 48'd1);
    step(7'b011_00_01, 4'b0000, 2'b11, 1'b0, 25'd0, 18'd0, 48'd1, 48'd0);
    chk("R2 illegal ignored with ce low", {47'd0, opErr}, 48'd0);
    @(negedge clk); ce = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset overrides ce", pOut, 48'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; ce = 1'b0; carryIn = 1'b0; aIn = '0; bIn = '0;
    cIn = '0; casIn = '0; opSel = '0; fnSel = '0; carrySel = '0;
    patIn = '0; maskIn = '1;
    repeat (2) @(posedge clk);
    t_reset();
    t_mult();
    t_addsub();
    t_logic();
    t_illegal();
    t_shift_cin();
    t_pattern();
    t_ce_reset();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule